// File: doc/BRIEF.md
# Carrier-Locked Sine Reference Generator

This block produces the digital modulating reference for a carrier-based PWM stage. It runs its own up/down triangle carrier counter. At each carrier peak it reads a folded sine table at a phase index that advances by one step per peak. The fundamental period is therefore an exact odd number of carrier periods, and the phase never drifts. The table output is scaled by a modulation index and held in a register until the next sample.

A mode input chooses how often the reference is refreshed. In single-rate mode the reference is sampled only at the top of the carrier and held for a full carrier period. In dual-rate mode it is sampled at both the top and the bottom and held for half a period. A one-cycle strobe marks every new sample. The carrier count is output alongside so that downstream comparators can use the same triangle.

Top module: `sync_sine_ref`

## Requirements
- R1: While `rst_n` is low, `carrier_o`, `strobe_o` and `ref_o` are all zero.
- R2: After reset, `carrier_o` counts 1, 2, … up to `HALF_CLK`, then back down to 0, and repeats with a period of 2·`HALF_CLK` clocks.
- R3: With `mode_i` = 0 (single-rate), `strobe_o` is high exactly in the cycles where `carrier_o` equals `HALF_CLK`, and never at the bottom.
- R4: With `mode_i` = 1 (dual-rate), `strobe_o` is also high in every cycle where `carrier_o` returns to 0 after reset.
- R5: Peaks are numbered from k = 1 after reset. Peak k uses phase index (k−1) mod 2·`PULSE_N`, which stands for the angle π·index/`PULSE_N`. Top peaks carry even indices. Samples taken at equal indices in successive fundamental periods, with the same modulation index, are identical.
- R6: A new sample equals floor(round(|sin θ|·(2^(`DATA_W`−1)−1))·`mi_i`/2^`MI_W`), carrying the sign of sin θ. It is exact to ±1 LSB, and exactly zero at indices 0 and `PULSE_N`.
- R7: In every cycle without a strobe, `ref_o` keeps its previous value.
- R8: A change of `mi_i` between two sample instants leaves `ref_o` unchanged until the next strobe. That sample uses the `mi_i` present at its clock edge.
- R9: A change of `mode_i` takes effect at the next carrier bottom. It does not reset or skip the phase index.
- R10: For equal `mi_i`, the sample at index i + `PULSE_N` is the exact negation of the sample at index i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 1 | 0: sample at carrier top only; 1: sample at top and bottom |
| mi_i | input | MI_W | Modulation index, unsigned fraction of 2^MI_W |
| carrier_o | output | $clog2(HALF_CLK+1) | Triangle carrier count |
| strobe_o | output | 1 | One-cycle pulse marking a new held sample |
| ref_o | output | DATA_W | Signed held reference sample |

## Verification
The hazard is a modulation-index or mode change landing on the very clock edge where the carrier reaches a peak. At that edge the sample load and the input change collide. The stimulus moves `mi_i` and `mode_i` at random negative edges, so some changes fall immediately before a peak edge and others fall mid-hold. The bench model evaluates each peak with the input values present at that edge. It requires `ref_o` to stay frozen on every other cycle and the phase index to keep counting through mode flips.

// File: rtl/sref_pkg.sv
package sref_pkg;

    localparam int unsigned FRAC_Q = 30;
    localparam longint      PI_FX  = 64'sd3373259426;

    typedef enum logic {
        SAMPLE_ONCE  = 1'b0,
        SAMPLE_TWICE = 1'b1
    } samp_mode_e;

    // Magnitude of sin(pi*k/n) scaled to amp, integer Taylor series in Q30.
    function automatic longint sine_fix(input int unsigned k, input int unsigned n,
                                        input longint amp);
        longint x;
        longint term;
        longint acc;
        longint v;
        x   = (PI_FX * longint'(k)) / longint'(n);
        term = x;
        acc  = x;
        for (int j = 1; j <= 6; j++) begin
            term = -((((term * x) >>> FRAC_Q) * x) >>> FRAC_Q) / longint'((2 * j) * (2 * j + 1));
            acc  = acc + term;
        end
        v = ((acc * amp) + (64'sd1 <<< (FRAC_Q - 1))) >>> FRAC_Q;
        if (v > amp) v = amp;
        if (v < 0)   v = 0;
        return v;
    endfunction

endpackage

// File: rtl/tri_carrier.sv
module tri_carrier #(
    parameter int HALF_CLK = 6,
    parameter int CNT_W    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] cnt_o,
    output logic             top_next_o,
    output logic             bot_next_o
);
    localparam logic [CNT_W-1:0] TOP    = CNT_W'(HALF_CLK);
    localparam logic [CNT_W-1:0] TOP_M1 = CNT_W'(HALF_CLK - 1);
    localparam logic [CNT_W-1:0] ONE    = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             rising;
    } car_st_t;

    car_st_t car_d, car_q;

    always_comb begin
        car_d      = car_q;
        top_next_o = 1'b0;
        bot_next_o = 1'b0;
        if (car_q.rising) begin
            if (car_q.cnt == TOP_M1) begin
                car_d.cnt    = TOP;
                car_d.rising = 1'b0;
                top_next_o   = 1'b1;
            end else begin
                car_d.cnt = car_q.cnt + ONE;
            end
        end else begin
            if (car_q.cnt == ONE) begin
                car_d.cnt    = '0;
                car_d.rising = 1'b1;
                bot_next_o   = 1'b1;
            end else begin
                car_d.cnt = car_q.cnt - ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            car_q.cnt    <= '0;
            car_q.rising <= 1'b1;
        end else begin
            car_q <= car_d;
        end
    end

    assign cnt_o = car_q.cnt;

endmodule

// File: rtl/phase_seq.sv
module phase_seq #(
    parameter int PULSE_N = 21,
    parameter int IDX_W   = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             peak_i,
    output logic [IDX_W-1:0] idx_o
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(2 * PULSE_N - 1);
    localparam logic [IDX_W-1:0] STEP = IDX_W'(1);

    typedef struct packed {
        logic [IDX_W-1:0] idx;
    } ph_st_t;

    ph_st_t ph_d, ph_q;

    always_comb begin
        ph_d = ph_q;
        if (peak_i) begin
            ph_d.idx = (ph_q.idx == LAST) ? '0 : ph_q.idx + STEP;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ph_q.idx <= '0;
        else        ph_q     <= ph_d;
    end

    assign idx_o = ph_q.idx;

endmodule

// File: rtl/quarter_sine_rom.sv
module quarter_sine_rom #(
    parameter int PULSE_N = 21,
    parameter int IDX_W   = 6,
    parameter int MAG_W   = 15
) (
    input  logic [IDX_W-1:0] idx_i,
    output logic [MAG_W-1:0] mag_o,
    output logic             neg_o
);
    localparam int               QN      = (PULSE_N + 1) / 2;
    localparam int               FOLD_W  = (QN > 1) ? $clog2(QN) : 1;
    localparam logic [IDX_W-1:0] N_IDX   = IDX_W'(PULSE_N);
    localparam logic [IDX_W-1:0] MID_IDX = IDX_W'((PULSE_N - 1) / 2);
    localparam longint           AMP     = (64'sd1 <<< MAG_W) - 64'sd1;

    logic [MAG_W-1:0] tbl [QN];
    logic [IDX_W-1:0] half_idx;
    logic [IDX_W-1:0] fold_idx;

    for (genvar g = 0; g < QN; g++) begin : g_tbl
        assign tbl[g] = MAG_W'(sref_pkg::sine_fix(g, PULSE_N, AMP));
    end

    always_comb begin
        neg_o    = (idx_i >= N_IDX);
        half_idx = neg_o ? (idx_i - N_IDX) : idx_i;
        fold_idx = (half_idx > MID_IDX) ? (N_IDX - half_idx) : half_idx;
        mag_o    = tbl[fold_idx[FOLD_W-1:0]];
    end

endmodule

// File: rtl/ref_hold.sv
module ref_hold #(
    parameter int MAG_W = 15,
    parameter int MI_W  = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    take_i,
    input  logic [MAG_W-1:0]        mag_i,
    input  logic                    neg_i,
    input  logic [MI_W-1:0]         mi_i,
    output logic                    strobe_o,
    output logic signed [MAG_W:0]   ref_o
);
    localparam int PROD_W = MAG_W + MI_W;

    typedef struct packed {
        logic signed [MAG_W:0] held;
        logic                  stb;
    } hold_st_t;

    hold_st_t hs_d, hs_q;
    logic [PROD_W-1:0]     prod;
    logic [MAG_W-1:0]      scaled;
    logic signed [MAG_W:0] mag_s;

    always_comb begin
        prod   = PROD_W'(mag_i) * PROD_W'(mi_i);
        scaled = prod[PROD_W-1:MI_W];
        mag_s  = {1'b0, scaled};
        hs_d   = hs_q;
        hs_d.stb = take_i;
        if (take_i) begin
            hs_d.held = neg_i ? -mag_s : mag_s;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hs_q.held <= '0;
            hs_q.stb  <= 1'b0;
        end else begin
            hs_q <= hs_d;
        end
    end

    assign strobe_o = hs_q.stb;
    assign ref_o    = hs_q.held;

endmodule

// File: rtl/sync_sine_ref.sv
module sync_sine_ref #(
    parameter int HALF_CLK = 6,
    parameter int PULSE_N  = 21,
    parameter int DATA_W   = 16,
    parameter int MI_W     = 8,
    localparam int CNT_W   = $clog2(HALF_CLK + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     mode_i,
    input  logic [MI_W-1:0]          mi_i,
    output logic [CNT_W-1:0]         carrier_o,
    output logic                     strobe_o,
    output logic signed [DATA_W-1:0] ref_o
);
    localparam int IDX_W = $clog2(2 * PULSE_N);
    localparam int MAG_W = DATA_W - 1;

    logic             top_next;
    logic             bot_next;
    logic             take;
    logic [IDX_W-1:0] idx;
    logic [MAG_W-1:0] mag;
    logic             neg;
    sref_pkg::samp_mode_e mode;

    assign mode = sref_pkg::samp_mode_e'(mode_i);
    assign take = top_next | (bot_next & (mode == sref_pkg::SAMPLE_TWICE));

    tri_carrier #(.HALF_CLK(HALF_CLK), .CNT_W(CNT_W)) u_car (
        .clk        (clk),
        .rst_n      (rst_n),
        .cnt_o      (carrier_o),
        .top_next_o (top_next),
        .bot_next_o (bot_next)
    );

    phase_seq #(.PULSE_N(PULSE_N), .IDX_W(IDX_W)) u_phase (
        .clk    (clk),
        .rst_n  (rst_n),
        .peak_i (top_next | bot_next),
        .idx_o  (idx)
    );

    quarter_sine_rom #(.PULSE_N(PULSE_N), .IDX_W(IDX_W), .MAG_W(MAG_W)) u_rom (
        .idx_i (idx),
        .mag_o (mag),
        .neg_o (neg)
    );

    ref_hold #(.MAG_W(MAG_W), .MI_W(MI_W)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .take_i   (take),
        .mag_i    (mag),
        .neg_i    (neg),
        .mi_i     (mi_i),
        .strobe_o (strobe_o),
        .ref_o    (ref_o)
    );

endmodule

// File: rtl/sync_sine_ref_chk.sv
module sync_sine_ref_chk #(
    parameter int HALF_CLK = 6,
    parameter int CNT_W    = 3,
    parameter int DATA_W   = 16
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     mode_i,
    input logic [CNT_W-1:0]         carrier_o,
    input logic                     strobe_o,
    input logic signed [DATA_W-1:0] ref_o
);
    localparam logic [CNT_W-1:0] TOP = CNT_W'(HALF_CLK);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    AST_CARRIER_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        carrier_o <= TOP); // R2

    AST_TOP_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (carrier_o == TOP) |-> strobe_o); // R3

    AST_STROBE_AT_PEAK: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_o |-> ((carrier_o == TOP) || (carrier_o == '0))); // R3

    AST_BOTTOM_TWICE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode_i) && (carrier_o == '0) && ($past(carrier_o) == ONE)) |-> strobe_o); // R4

    AST_BOTTOM_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(mode_i) && (carrier_o == '0)) |-> !strobe_o); // R9

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe_o |-> $stable(ref_o)); // R7

endmodule

bind sync_sine_ref sync_sine_ref_chk #(
    .HALF_CLK (HALF_CLK),
    .CNT_W    (CNT_W),
    .DATA_W   (DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_i    (mode_i),
    .carrier_o (carrier_o),
    .strobe_o  (strobe_o),
    .ref_o     (ref_o)
);

// File: tb/sync_sine_ref_tb.sv
`timescale 1ns/1ps
module sync_sine_ref_tb;
    localparam int  HALF   = 6;
    localparam int  PN     = 21;
    localparam int  DATA_W = 16;
    localparam int  MI_W   = 8;
    localparam int  CNT_W  = $clog2(HALF + 1);
    localparam int  AMP    = (1 << (DATA_W - 1)) - 1;
    localparam real PI_R   = 3.14159265358979323846;

    logic                     clk = 1'b0;
    logic                     rst_n = 1'b0;
    logic                     mode = 1'b0;
    logic [MI_W-1:0]          mi = '0;
    logic [CNT_W-1:0]         car_w;
    logic                     stb_w;
    logic signed [DATA_W-1:0] ref_w;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // model state
    int  c = 0;
    int  exp_car = 0;
    bit  exp_stb = 1'b0;
    int  exp_ref = 0;
    int  cur_idx = 0;
    bit  at_peak = 1'b0;
    bit  mi_moved = 1'b0;
    bit  mode_moved = 1'b0;
    string stb_tag = "R3";
    bit  rec_en = 1'b0;
    int  obs  [2*PN];
    bit  seen [2*PN];

    always #10 clk = ~clk;

    sync_sine_ref #(.HALF_CLK(HALF), .PULSE_N(PN), .DATA_W(DATA_W), .MI_W(MI_W)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_i    (mode),
        .mi_i      (mi),
        .carrier_o (car_w),
        .strobe_o  (stb_w),
        .ref_o     (ref_w)
    );

    function automatic int exp_val(int idx, int m);
        real s;
        int  mag;
        int  sc;
        s   = $sin(PI_R * idx / PN);
        mag = $rtoi(((s < 0.0) ? -s : s) * AMP + 0.5);
        sc  = (mag * m) >>> MI_W;
        return (s < 0.0) ? -sc : sc;
    endfunction

    task automatic check(string tag, int got, int exp, int tol);
        int d;
        n_chk++;
        d = got - exp;
        if (d < 0) d = -d;
        if (d > tol) begin
            n_bad++;
            $display("FAIL %s got=%0d exp=%0d (cycle %0d)", tag, got, exp, c);
        end
    endtask

    task automatic model_edge();
        int p;
        int k;
        c++;
        p = c % (2 * HALF);
        exp_car = (p <= HALF) ? p : 2 * HALF - p;
        exp_stb = 1'b0;
        at_peak = 1'b0;
        if (exp_car == HALF || exp_car == 0) begin
            k = c / HALF;
            cur_idx = (k - 1) % (2 * PN);
            at_peak = 1'b1;
            stb_tag = mode_moved ? "R9" : (mode ? "R4" : "R3");
            if (exp_car == HALF || mode) begin
                exp_stb = 1'b1;
                exp_ref = exp_val(cur_idx, int'(mi));
            end
        end
    endtask

    task automatic compare();
        int tol;
        check("R2 carrier", int'(car_w), exp_car, 0);
        check({stb_tag, " strobe"}, int'(stb_w), int'(exp_stb), 0);
        if (exp_stb) begin
            tol = (cur_idx == 0 || cur_idx == PN) ? 0 : 1;
            check("R6 sample", int'(ref_w), exp_ref, tol);
            if (rec_en) begin
                if (seen[cur_idx]) check("R5 repeat", int'(ref_w), obs[cur_idx], 0);
                else begin
                    obs[cur_idx]  = int'(ref_w);
                    seen[cur_idx] = 1'b1;
                end
            end
            mi_moved = 1'b0;
        end else begin
            check(mi_moved ? "R8 hold" : "R7 hold", int'(ref_w), exp_ref, 1);
        end
        if (at_peak) mode_moved = 1'b0;
    endtask

    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare();
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R1 carrier", int'(car_w), 0, 0);
        check("R1 strobe", int'(stb_w), 0, 0);
        check("R1 ref", int'(ref_w), 0, 0);
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        c = 0; exp_ref = 0; exp_stb = 1'b0; exp_car = 0;
        mi_moved = 1'b0; mode_moved = 1'b0;
    endtask

    initial begin
        int len;
        int cut;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check("R1 carrier", int'(car_w), 0, 0);
        check("R1 strobe", int'(stb_w), 0, 0);
        check("R1 ref", int'(ref_w), 0, 0);
        do_reset();

        // directed: dual-rate, fixed index, two full periods recorded
        mode = 1'b1;
        mi   = 8'd200;
        for (int i = 0; i < 2 * PN; i++) seen[i] = 1'b0;
        rec_en = 1'b1;
        repeat (2 * (2 * PN) * HALF + 2 * HALF) step();
        rec_en = 1'b0;
        for (int i = 0; i < PN; i++) begin
            check("R10 mirror", obs[i + PN], -obs[i], 0);
        end
        check("R6 zero idx0", obs[0], 0, 0);
        check("R6 zero idxN", obs[PN], 0, 0);

        // directed: single-rate full scale, then zero index
        mode = 1'b0; mode_moved = 1'b1;
        mi = 8'hFF;
        repeat (4 * PN * HALF) step();
        mi = 8'd0; mi_moved = 1'b1;
        repeat (8 * HALF) step();

        // directed: mi change one cycle before a peak edge
        mi = 8'd128;
        while (exp_car != HALF - 1) step();
        mi = 8'd37; mi_moved = 1'b1;
        step();

        // mid-run reset
        do_reset();

        // random segments
        for (int seg = 0; seg < 40; seg++) begin
            if (($urandom % 2) == 1) begin
                mode = ~mode;
                mode_moved = 1'b1;
            end
            case ($urandom % 4)
                0: mi = 8'd0;
                1: mi = 8'hFF;
                default: mi = MI_W'($urandom);
            endcase
            mi_moved = 1'b1;
            len = 50 + int'($urandom % 150);
            cut = int'($urandom % len);
            for (int t = 0; t < len; t++) begin
                if (t == cut) begin
                    mi = MI_W'($urandom);
                    mi_moved = 1'b1;
                end
                step();
            end
        end

        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired got=running exp=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule